// File: doc/BRIEF.md
# Masked LFSR Pseudonoise Generator

This block produces a 12-bit pseudonoise code for one converter channel. A 12-bit linear feedback shift register runs a fixed polynomial from a fixed seed. When a selected trigger arrives while noise mode is chosen, the block takes a slice of the register's low bits, adds it to a base value without wrapping, and loads the result into the output register a fixed three clocks later. In that same clock the shift register takes one step.

A trigger is one line picked out of a trigger vector by a select field, and it is gated by an enable. The base value and the mask code are captured in the cycle the trigger is seen. The output changes only when a committed trigger reaches the end of the pipeline. The register state is brought out on a port so that it can be observed. The block contains no analog stage and no bus logic.

Top module: `pn_noise_source`

## Requirements
- R1: While reset is asserted and right after it is released, `lfsr_state` is 12'hAAA and `out_val` is 0.
- R2: A trigger event is a rising clock edge at which `trig_en` is 1, `trig_vec[trig_sel]` is 1 and `wave_mode` is 2'b01. The `hold_val` and `mask_code` values at that edge are the ones used for that event, whatever those inputs do afterwards.
- R3: `out_val` and `lfsr_state` take their new values at the third rising edge after the edge that sampled the event. They do not change at any edge where no event completes.
- R4: No event is taken if `trig_en` is 0, if the selected line is 0 while other lines are 1, or if `wave_mode` is 2'b00, 2'b10 or 2'b11. In each of these cases both outputs stay unchanged.
- R5: One step maps state s to {s[10:0], s[11]^s[5]^s[3]^s[0]^NOR(s)}. The register shifts toward the MSB, and the new bit enters at bit 0.
- R6: `lfsr_state` is never 12'h000.
- R7: Mask code n (0..10) keeps LFSR bits [n:0] and clears the bits above them. Codes 11 to 15 keep all 12 bits.
- R8: The committed value is hold + masked LFSR, clamped to 12'hFFF when the sum exceeds 4095.
- R9: Events on consecutive cycles each commit, in order, on consecutive edges. Each one uses the next state of the register.
- R10: The sum uses the register state from before the step taken at the same commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en | input | 1 | Trigger enable |
| trig_sel | input | 3 | Selects one line of the trigger vector |
| trig_vec | input | 8 | Candidate trigger lines |
| wave_mode | input | 2 | Waveform mode, 2'b01 selects noise |
| mask_code | input | 4 | Number of LFSR bits kept, minus one |
| hold_val | input | 12 | Base value the noise is added to |
| out_val | output | 12 | Output data register |
| lfsr_state | output | 12 | Present shift register state |

## Verification
The assertions assume that the bound checker sees the same trigger inputs as the design. They also assume that all inputs are free of X at every sampled edge, because the checker derives its own commit timing from those inputs. The bench drives every input to a known value before reset is released and changes inputs only at falling edges. It covers all sixteen mask codes with several base values, including ones that force clamping. It also drives consecutive events and a long unbroken run of triggers, following the register sequence in an arithmetic model of its own.

// File: rtl/pn_noise_pkg.sv
package pn_noise_pkg;
  localparam int LW = 12;
  localparam int MW = 4;
  localparam logic [LW-1:0] LSEED = 12'hAAA;

  typedef logic [LW-1:0] word_t;

  typedef struct packed {
    logic [MW-1:0] mask;
    word_t         base;
  } req_t;
endpackage

// File: rtl/pn_trig_pipe.sv
module pn_trig_pipe
  import pn_noise_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int LATENCY = 3,
  localparam int NTRIG  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [NTRIG-1:0] trig_vec,
  input  logic [1:0]       wave_mode,
  input  logic [MW-1:0]    mask_code,
  input  word_t            hold_val,
  output logic             commit,
  output req_t             cmd
);
  logic fire;
  req_t in_req;
  logic vld_q [LATENCY];
  req_t dat_q [LATENCY];

  always_comb begin
    fire        = trig_en & trig_vec[trig_sel] & (wave_mode == 2'b01);
    in_req.mask = mask_code;
    in_req.base = hold_val;
  end

  for (genvar g = 0; g < LATENCY; g++) begin : g_stage
    logic vld_d;
    req_t dat_d;
    if (g == 0) begin : g_head
      always_comb begin
        vld_d = fire;
        dat_d = fire ? in_req : dat_q[0];
      end
    end else begin : g_body
      always_comb begin
        vld_d = vld_q[g-1];
        dat_d = vld_q[g-1] ? dat_q[g-1] : dat_q[g];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        dat_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_d;
        dat_q[g] <= dat_d;
      end
    end
  end

  assign commit = vld_q[LATENCY-1];
  assign cmd    = dat_q[LATENCY-1];
endmodule

// File: rtl/pn_lfsr12.sv
module pn_lfsr12
  import pn_noise_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output word_t state
);
  word_t state_q, state_d;
  logic  lock_esc, fb;

  always_comb begin
    lock_esc = ~(|state_q);
    fb       = state_q[11] ^ state_q[5] ^ state_q[3] ^ state_q[0] ^ lock_esc;
    state_d  = step ? {state_q[LW-2:0], fb} : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LSEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pn_mask_sat_add.sv
module pn_mask_sat_add
  import pn_noise_pkg::*;
(
  input  word_t         noise,
  input  logic [MW-1:0] mask_code,
  input  word_t         base,
  output word_t         result
);
  word_t       keep;
  logic [LW:0] wide;

  for (genvar b = 0; b < LW; b++) begin : g_keep
    assign keep[b] = (mask_code >= MW'(b));
  end

  always_comb begin
    wide   = {1'b0, base} + {1'b0, noise & keep};
    result = wide[LW] ? {LW{1'b1}} : wide[LW-1:0];
  end
endmodule

// File: rtl/pn_noise_source.sv
module pn_noise_source
  import pn_noise_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int LATENCY = 3,
  localparam int NTRIG  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [NTRIG-1:0] trig_vec,
  input  logic [1:0]       wave_mode,
  input  logic [MW-1:0]    mask_code,
  input  logic [LW-1:0]    hold_val,
  output logic [LW-1:0]    out_val,
  output logic [LW-1:0]    lfsr_state
);
  logic  commit;
  req_t  cmd;
  word_t noise, sum, out_q, out_d;

  pn_trig_pipe #(.SEL_W(SEL_W), .LATENCY(LATENCY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_sel(trig_sel),
    .trig_vec(trig_vec), .wave_mode(wave_mode), .mask_code(mask_code),
    .hold_val(hold_val), .commit(commit), .cmd(cmd)
  );

  pn_lfsr12 u_lfsr (.clk(clk), .rst_n(rst_n), .step(commit), .state(noise));

  pn_mask_sat_add u_add (
    .noise(noise), .mask_code(cmd.mask), .base(cmd.base), .result(sum)
  );

  always_comb out_d = commit ? sum : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_val    = out_q;
  assign lfsr_state = noise;
endmodule

// File: rtl/pn_noise_chk.sv
module pn_noise_chk #(
  parameter int SEL_W   = 3,
  parameter int LATENCY = 3,
  localparam int NTRIG  = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_en,
  input logic [SEL_W-1:0] trig_sel,
  input logic [NTRIG-1:0] trig_vec,
  input logic [1:0]       wave_mode,
  input logic [11:0]      hold_val,
  input logic [11:0]      out_val,
  input logic [11:0]      lfsr_state
);
  logic        pv [LATENCY];
  logic [11:0] ph [LATENCY];
  logic        ev, done_c;
  logic [11:0] base_c;

  assign ev     = trig_en && trig_vec[trig_sel] && (wave_mode == 2'b01);
  assign done_c = pv[LATENCY-1];
  assign base_c = ph[LATENCY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LATENCY; i++) begin
        pv[i] <= 1'b0;
        ph[i] <= '0;
      end
    end else begin
      for (int i = LATENCY - 1; i > 0; i--) begin
        pv[i] <= pv[i-1];
        ph[i] <= ph[i-1];
      end
      pv[0] <= ev;
      ph[0] <= hold_val;
    end
  end

  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != 12'h000);

  a_r3_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done_c |=> ($stable(out_val) && $stable(lfsr_state)));

  a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    done_c |=> (lfsr_state[11:1] == $past(lfsr_state[10:0])));

  a_r8_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    done_c |=> (out_val >= $past(base_c)));
endmodule

bind pn_noise_source pn_noise_chk #(.SEL_W(SEL_W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_sel(trig_sel),
  .trig_vec(trig_vec), .wave_mode(wave_mode), .hold_val(hold_val),
  .out_val(out_val), .lfsr_state(lfsr_state)
);

// File: tb/test_pn_noise_source.sv
`timescale 1ns/1ps
module test_pn_noise_source;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_en;
  logic [2:0]  trig_sel;
  logic [7:0]  trig_vec;
  logic [1:0]  wave_mode;
  logic [3:0]  mask_code;
  logic [11:0] hold_val;
  logic [11:0] out_val, lfsr_state;

  int checks = 0;
  int fails  = 0;
  logic [11:0] ref_lfsr, ref_out;

  always #10 clk = ~clk;

  pn_noise_source i_pn_noise_source (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_sel(trig_sel),
    .trig_vec(trig_vec), .wave_mode(wave_mode), .mask_code(mask_code),
    .hold_val(hold_val), .out_val(out_val), .lfsr_state(lfsr_state)
  );

  function automatic logic [11:0] nxt(logic [11:0] s);
    logic z;
    z = (s == 12'd0);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0] ^ z};
  endfunction

  function automatic logic [11:0] mask_of(logic [3:0] n);
    if (n >= 4'd11) return 12'hFFF;
    return 12'hFFF >> (11 - int'(n));
  endfunction

  function automatic logic [11:0] sat(logic [11:0] a, logic [11:0] b);
    int s;
    s = int'(a) + int'(b);
    return (s > 4095) ? 12'hFFF : 12'(s);
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    trig_en = 1'b0; trig_vec = '0; trig_sel = '0;
    wave_mode = 2'b01; mask_code = 4'd15; hold_val = '0;
  endtask

  // one event, then scrambled inputs (R2), checked before and at commit (R3)
  task automatic fire(int sel, logic [3:0] m, logic [11:0] h);
    logic [11:0] eo;
    @(negedge clk);
    trig_en = 1'b1; trig_sel = 3'(sel); trig_vec = 8'(1 << sel);
    wave_mode = 2'b01; mask_code = m; hold_val = h;
    eo = sat(h, ref_lfsr & mask_of(m));
    @(negedge clk);
    trig_en = 1'b0; trig_vec = '0; mask_code = ~m; hold_val = ~h;
    @(negedge clk);
    @(negedge clk);
    chk("R3 before third edge", out_val, ref_out);
    @(negedge clk);
    ref_out  = eo;
    ref_lfsr = nxt(ref_lfsr);
    chk("R2 R7 R8 R10 committed value", out_val, ref_out);
    chk("R5 stepped state", lfsr_state, ref_lfsr);
  endtask

  task automatic no_event(string tag);
    repeat (6) @(negedge clk);
    chk({tag, " out"}, out_val, ref_out);
    chk({tag, " lfsr"}, lfsr_state, ref_lfsr);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] hv [4];
    logic [11:0] expv [40];
    hv[0] = 12'h000; hv[1] = 12'h7FF; hv[2] = 12'hF00; hv[3] = 12'hFFF;
    rst_n = 1'b1;
    idle();
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", lfsr_state, 12'hAAA);
    chk("R1 output in reset", out_val, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after release", lfsr_state, 12'hAAA);
    chk("R1 output after release", out_val, 12'h000);
    ref_lfsr = 12'hAAA;
    ref_out  = 12'h000;

    // sweep every mask code against several bases (R7, R8)
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++)
        fire((m + k) % 8, 4'(m), hv[k]);

    // exact fit versus clamp boundary (R8)
    fire(2, 4'd15, 12'hFFF - ref_lfsr);
    fire(5, 4'd15, (12'hFFF - ref_lfsr) + 12'd1);

    // ignored stimuli (R4)
    @(negedge clk);
    trig_en = 1'b0; trig_vec = 8'hFF;
    no_event("R4 enable low");
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      trig_en = 1'b1; trig_sel = 3'(s); trig_vec = ~8'(1 << s);
      no_event("R4 selected line low");
    end
    for (int w = 0; w < 4; w++) begin
      if (w == 1) continue;
      @(negedge clk);
      trig_en = 1'b1; trig_sel = 3'd3; trig_vec = 8'hFF; wave_mode = 2'(w);
      no_event("R4 other wave mode");
    end

    // two events on consecutive cycles (R9)
    begin
      logic [11:0] e1, e2, l1, l2;
      e1 = sat(12'h100, ref_lfsr & mask_of(4'd3));
      l1 = nxt(ref_lfsr);
      e2 = sat(12'h200, l1 & mask_of(4'd7));
      l2 = nxt(l1);
      @(negedge clk);
      trig_en = 1'b1; trig_sel = 3'd1; trig_vec = 8'h02; wave_mode = 2'b01;
      mask_code = 4'd3; hold_val = 12'h100;
      @(negedge clk);
      mask_code = 4'd7; hold_val = 12'h200;
      @(negedge clk);
      idle();
      @(negedge clk);
      @(negedge clk);
      chk("R9 first commit out", out_val, e1);
      chk("R9 first commit lfsr", lfsr_state, l1);
      @(negedge clk);
      chk("R9 second commit out", out_val, e2);
      chk("R9 second commit lfsr", lfsr_state, l2);
      ref_out = e2; ref_lfsr = l2;
    end

    // unbroken run of 40 events, full mask, zero base (R9, R6)
    for (int j = 0; j < 40; j++) begin
      expv[j]  = ref_lfsr;
      ref_lfsr = nxt(ref_lfsr);
    end
    for (int i = 0; i < 44; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk("R9 run output", out_val, expv[i-4]);
        checks++;
        if (lfsr_state == 12'h000) begin
          fails++;
          $display("FAIL R6 actual=%h expected=nonzero", lfsr_state);
        end
      end
      if (i < 40) begin
        trig_en = 1'b1; trig_sel = 3'd6; trig_vec = 8'h40;
        wave_mode = 2'b01; mask_code = 4'd11; hold_val = 12'h000;
      end else begin
        idle();
      end
    end
    ref_out = expv[39];
    chk("R5 state after run", lfsr_state, ref_lfsr);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule